// File: doc/BRIEF.md
# Oscillator-Stepped Waveform Memory Addresser

This block drives the read address of a waveform sample memory and runs the phase accumulator of a numerically controlled oscillator beside it. The address counter sweeps a programmed window, from a start address to a stop address and back to the start. It advances on every sample clock, or only once per oscillator cycle. In the second mode the memory steps in time with the synthesized output instead of with the sample clock.

The accumulator adds a tuning word on every clock. A 16-bit offset is added after the accumulator to form the output phase. That offset comes from a programmed register. When phase-from-memory is enabled, it comes instead from the 8 most significant bits of the 14-bit memory word now being read, so each stored sample can carry a phase value. A one-cycle flag marks every rising edge of the accumulator's top bit, which is one oscillator cycle. A restart input returns the channel to its start state.

Top module: `wave_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the accumulator clears, its registered top-bit copy clears and the address loads start_addr. After reset, mem_addr equals start_addr, cyc_flag is 0 and phase_out equals the selected offset.
- R2: Each clock without restart adds tune_word to the 24-bit accumulator, modulo 2^24. phase_out is always the accumulator's top 16 bits plus the selected offset, modulo 2^16, with no register between them.
- R3: With mem_ph_en at 1, the offset is mem_word[13:6] placed in bits 15:8 of a 16-bit value with bits 7:0 at zero, and phase_ofs has no effect. With mem_ph_en at 0, the offset is phase_ofs.
- R4: cyc_flag is 1 in exactly those cycles where the accumulator's top bit (bit 23) is 1 and was 0 in the previous cycle. A restart or reset leaves the stored previous value at 0.
- R5: With step_sel at 0 (sample-clock stepping), mem_addr advances by one on every clock that has no restart.
- R6: With step_sel at 1 (oscillator stepping), mem_addr advances at the clock that ends a cycle with cyc_flag at 1, and holds at every other clock.
- R7: A step taken while mem_addr equals stop_addr loads start_addr instead of incrementing.
- R8: A clock with restart at 1 loads start_addr into the address and clears the accumulator and the top-bit copy. Restart wins over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Channel restart, applied at the next edge |
| tune_word | input | 24 | Accumulator increment per clock |
| phase_ofs | input | 16 | Programmed phase offset |
| start_addr | input | 12 | First address of the window |
| stop_addr | input | 12 | Last address of the window |
| step_sel | input | 1 | 0: step every clock, 1: step once per oscillator cycle |
| mem_ph_en | input | 1 | Take the phase offset from the memory word |
| mem_word | input | 14 | Sample word read at mem_addr |
| mem_addr | output | 12 | Memory read address |
| phase_out | output | 16 | Accumulator phase plus offset |
| cyc_flag | output | 1 | Rising edge of the accumulator top bit |

## Verification
Three events can land on the same clock. An oscillator cycle edge can coincide with the address reaching stop_addr, and a restart can arrive in the cycle whose edge would have stepped the address. The bench provokes both. It uses short address windows, including start equal to stop, and large tuning words so that edges come every few cycles. Restarts are issued at random. A bench reference model applies the required priority (restart first, then the wrap to start, then the increment) and judges every cycle's address, flag and phase against it.

// File: rtl/wave_addr_pkg.sv
// Shared types for the waveform addresser.
package wave_addr_pkg;
    // Source of the address step.
    typedef enum logic {
        STEP_EVERY_CLK = 1'b0,
        STEP_OSC_CYCLE = 1'b1
    } step_src_e;
endpackage

// File: rtl/wag_phase_acc.sv
// Phase accumulator with top-bit rising-edge detection.
// Assumes ACC_W >= PHASE_W. Restart clears the sum and the stored top bit.
module wag_phase_acc #(
    parameter int ACC_W   = 24,
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [ACC_W-1:0]   tune_word,
    output logic [PHASE_W-1:0] acc_top,
    output logic               msb_rise
);
    logic [ACC_W-1:0] acc_q;
    logic             msb_q;

    // Accumulate the tuning word and keep last cycle's top bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc_q <= '0;
            msb_q <= 1'b0;
        end else begin
            acc_q <= acc_q + tune_word;
            msb_q <= acc_q[ACC_W-1];
        end
    end

    // Expose the phase bits and the oscillator-cycle edge.
    always_comb begin
        acc_top  = acc_q[ACC_W-1 -: PHASE_W];
        msb_rise = acc_q[ACC_W-1] & ~msb_q;
    end
endmodule

// File: rtl/wag_phase_sum.sv
// Offset selection and phase addition.
// The memory phase takes the top MEMPH_W bits of the sample word and is left-aligned.
module wag_phase_sum #(
    parameter int PHASE_W  = 16,
    parameter int SAMPLE_W = 14,
    parameter int MEMPH_W  = 8
) (
    input  logic [PHASE_W-1:0]  acc_top,
    input  logic [PHASE_W-1:0]  phase_ofs,
    input  logic [SAMPLE_W-1:0] mem_word,
    input  logic                mem_ph_en,
    output logic [PHASE_W-1:0]  phase_out
);
    localparam int LOW_W = SAMPLE_W - MEMPH_W;

    logic [PHASE_W-1:0] mem_ofs;
    logic [LOW_W-1:0]   mem_low_unused;

    assign mem_low_unused = mem_word[LOW_W-1:0];

    generate
        if (PHASE_W > MEMPH_W) begin : g_pad
            // Left-align the memory phase and zero-fill the low bits.
            always_comb mem_ofs = {mem_word[SAMPLE_W-1 -: MEMPH_W], {(PHASE_W-MEMPH_W){1'b0}}};
        end else begin : g_trunc
            // The memory phase fills the whole offset.
            always_comb mem_ofs = mem_word[SAMPLE_W-1 -: PHASE_W];
        end
    endgenerate

    // Add the selected offset after the accumulator.
    always_comb phase_out = acc_top + (mem_ph_en ? mem_ofs : phase_ofs);
endmodule

// File: rtl/wag_addr_ctr.sv
// Window address counter: sweeps start..stop and wraps to start.
// Assumes start <= stop. Otherwise it counts through the top and rolls over until it meets stop.
module wag_addr_ctr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stop_addr,
    output logic [ADDR_W-1:0] addr
);
    // Load on reset or restart, then step with a wrap at stop.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            addr <= start_addr;
        else if (step_en)
            addr <= (addr == stop_addr) ? start_addr : addr + 1'b1;
    end
endmodule

// File: rtl/wave_addr_gen.sv
// Top: waveform memory addresser stepped by the sample clock or the oscillator.
// The memory word must belong to the current mem_addr (combinational read).
module wave_addr_gen #(
    parameter int ACC_W    = 24,
    parameter int PHASE_W  = 16,
    parameter int SAMPLE_W = 14,
    parameter int MEMPH_W  = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [ACC_W-1:0]    tune_word,
    input  logic [PHASE_W-1:0]  phase_ofs,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [ADDR_W-1:0]   stop_addr,
    input  logic                step_sel,
    input  logic                mem_ph_en,
    input  logic [SAMPLE_W-1:0] mem_word,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [PHASE_W-1:0]  phase_out,
    output logic                cyc_flag
);
    import wave_addr_pkg::*;

    logic [PHASE_W-1:0] acc_top;
    logic               msb_rise;
    logic               step_en;
    step_src_e          step_src;

    wag_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tune_word(tune_word),
        .acc_top(acc_top), .msb_rise(msb_rise)
    );

    wag_phase_sum #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .MEMPH_W(MEMPH_W)) u_sum (
        .acc_top(acc_top), .phase_ofs(phase_ofs), .mem_word(mem_word),
        .mem_ph_en(mem_ph_en), .phase_out(phase_out)
    );

    // Choose the step source for the address counter.
    always_comb begin
        step_src = step_src_e'(step_sel);
        step_en  = (step_src == STEP_OSC_CYCLE) ? msb_rise : 1'b1;
    end

    wag_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step_en(step_en),
        .start_addr(start_addr), .stop_addr(stop_addr), .addr(mem_addr)
    );

    assign cyc_flag = msb_rise;
endmodule

// File: rtl/wave_addr_gen_chk.sv
// Checker for the addresser's port-level stepping rules; bound to every instance.
module wave_addr_gen_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              step_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] stop_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cyc_flag
);
    // R8: restart loads the start address.
    assert_restart_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> mem_addr == $past(start_addr));

    // R5: sample-clock stepping increments away from stop.
    assert_clk_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !step_sel && mem_addr != stop_addr) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R7: a step taken at stop returns to start.
    assert_stop_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && mem_addr == stop_addr && (!step_sel || cyc_flag)) |=> mem_addr == $past(start_addr));

    // R6: oscillator stepping holds without an edge.
    assert_osc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && step_sel && !cyc_flag) |=> $stable(mem_addr));

    // R4: an edge flag never lasts two cycles.
    assert_flag_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_flag |=> !cyc_flag);
endmodule

bind wave_addr_gen wave_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step_sel(step_sel),
    .start_addr(start_addr), .stop_addr(stop_addr), .mem_addr(mem_addr), .cyc_flag(cyc_flag)
);

// File: tb/wave_addr_gen_bench.sv
// Randomized bench with a reference model of the addresser.
module wave_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [23:0] tune_word = '0;
    logic [15:0] phase_ofs = '0;
    logic [11:0] start_addr = 12'h010;
    logic [11:0] stop_addr = 12'h014;
    logic        step_sel = 1'b0;
    logic        mem_ph_en = 1'b0;
    logic [13:0] mem_word = '0;
    logic [11:0] mem_addr;
    logic [15:0] phase_out;
    logic        cyc_flag;

    int errors = 0;
    int checks = 0;

    logic [23:0] m_acc;
    logic        m_msbq;
    logic [11:0] m_addr;
    string       addr_tag = "R1";

    always #10 clk = ~clk;

    wave_addr_gen u_wave_addr_gen (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tune_word(tune_word),
        .phase_ofs(phase_ofs), .start_addr(start_addr), .stop_addr(stop_addr),
        .step_sel(step_sel), .mem_ph_en(mem_ph_en), .mem_word(mem_word),
        .mem_addr(mem_addr), .phase_out(phase_out), .cyc_flag(cyc_flag)
    );

    function automatic logic [15:0] exp_phase(logic [23:0] acc, logic [15:0] ofs,
                                              logic [13:0] mw, logic en);
        logic [15:0] sel;
        sel = en ? {mw[13:6], 8'h00} : ofs;
        return acc[23:8] + sel;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Check outputs for the current inputs, then advance model and clock.
    task automatic cycle();
        logic w, st;
        #1;
        chk(mem_ph_en ? "R3" : "R2", 32'(phase_out), 32'(exp_phase(m_acc, phase_ofs, mem_word, mem_ph_en)));
        chk("R4", 32'(cyc_flag), 32'(m_acc[23] & ~m_msbq));
        chk(addr_tag, 32'(mem_addr), 32'(m_addr));
        if (restart) begin
            m_acc = '0; m_msbq = 1'b0; m_addr = start_addr; addr_tag = "R8";
        end else begin
            w  = m_acc[23] & ~m_msbq;
            st = step_sel ? w : 1'b1;
            m_msbq = m_acc[23];
            m_acc  = m_acc + tune_word;
            addr_tag = step_sel ? "R6" : "R5";
            if (st) begin
                if (m_addr == stop_addr) begin
                    m_addr = start_addr; addr_tag = "R7";
                end else
                    m_addr = m_addr + 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A7));
        phase_ofs = 16'h1234;
        @(posedge clk); @(posedge clk); @(negedge clk);
        m_acc = '0; m_msbq = 1'b0; m_addr = start_addr;
        // R1: reset state
        chk("R1", 32'(mem_addr), 32'(start_addr));
        chk("R1", 32'(cyc_flag), 32'd0);
        chk("R1", 32'(phase_out), 32'h1234);
        rst_n = 1'b1;

        // R3 directed: memory phase replaces register, low bits zero
        mem_ph_en = 1'b1; mem_word = 14'h3FC5; phase_ofs = 16'hABCD;
        #1 chk("R3", 32'(phase_out), 32'hFF00);
        mem_ph_en = 1'b0;

        // R5/R7 directed: clock stepping across a short window
        tune_word = 24'h100000;
        for (int i = 0; i < 12; i++) cycle();

        // R6/R7 directed: oscillator stepping, start equal to stop
        step_sel = 1'b1; stop_addr = start_addr;
        for (int i = 0; i < 40; i++) cycle();

        // R4 directed: half-scale tuning toggles the top bit every clock
        tune_word = 24'h800000; start_addr = 12'h020; stop_addr = 12'h022;
        restart = 1'b1; cycle(); restart = 1'b0;
        for (int i = 0; i < 16; i++) cycle();

        // Random phase: frequent edges, short windows, random restarts
        for (int i = 0; i < 3000; i++) begin
            restart   = ($urandom_range(0, 19) == 0);
            if (restart) begin
                start_addr = 12'($urandom_range(0, 4000));
                stop_addr  = start_addr + 12'($urandom_range(0, 5));
            end
            if ($urandom_range(0, 49) == 0) step_sel = ~step_sel;
            if ($urandom_range(0, 29) == 0) tune_word = 24'($urandom_range(24'h080000, 24'hFFFFFF));
            mem_ph_en = $urandom_range(0, 1) == 1;
            mem_word  = 14'($urandom);
            phase_ofs = 16'($urandom);
            cycle();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule